// File: doc/BRIEF.md
# Programmable Local Bus Chip-Select Sequencer

This block sits behind a host-bus bridge and produces the active-low chip-select strobes for a small local peripheral bus. The bridge sends a one-clock start pulse in the clock where the bus master raises its ready strobe. Along with it come a read/write flag, a two-bit target index and a pair of region-hit flags. When the block accepts the pulse, it captures the access. It then holds the selected chip-select low over a window whose edges are counted in clocks from a reference cycle, which falls two clocks after the start pulse.

The window edges come from 4-bit fields of a 32-bit timing word. A read access uses one pair of assert/release fields and a write access uses the other. A mode input selects the second bus style, in which these fields are ignored and a fixed window is used. A one-clock done pulse closes each access. The block ignores any start pulse that arrives while an access is in flight.

Top module: `lbcs_seq`

## Requirements
- R1: While reset is high, and in the clock after it, all four chip-selects are high (1), and busy and done are low.
- R2: Call the clock with an accepted start pulse cycle 0. For a read in field mode (mode input 0), the selected chip-select is low in cycles 2+A through 2+D-1. A is timing bits 3:0 and D is timing bits 7:4, and this applies when D > A.
- R3: For a write in field mode, A is taken from timing bits 11:8 and D from timing bits 15:12, with the same cycle placement as R2.
- R4: When D <= A, the chip-select is low for exactly one clock, in cycle 2+A.
- R5: Only the chip-select indexed by the target input (cs_n_o[target]) is ever driven low. The other three stay high throughout.
- R6: In the fixed-window mode (mode input 1), the chip-select is low in cycles 2, 3 and 4 whatever the timing word holds, for both reads and writes.
- R7: done_o is high for exactly one clock, in the clock after the chip-select returns high (cycle 3+D, with D adjusted as in R4 and R6). busy_o is high from cycle 1 through that done cycle.
- R8: A start pulse that arrives while busy_o is high is ignored, and the access in flight keeps its target and timing.
- R9: A start pulse with both region-hit bits low is ignored. busy_o stays low and no chip-select moves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-clock pulse in the clock where the master ready strobe rises |
| write_i | input | 1 | 1 = write access, 0 = read access |
| target_i | input | 2 | Index of the chip-select to drive |
| region_hit_i | input | 2 | One flag per qualifying base-address region |
| moto_mode_i | input | 1 | 1 = fixed-window bus style, 0 = field-timed style |
| timing_i | input | 32 | Timing word holding the 4-bit window fields |
| cs_n_o | output | 4 | Active-low chip-selects |
| busy_o | output | 1 | Access in flight |
| done_o | output | 1 | One-clock pulse at the close of an access |

## Verification
The hardest cases are at the ends of the window: an assert offset of 15 with a release offset at or below it, and offsets of zero, where the strobe falls in the reference cycle itself. The stimulus therefore sweeps every assert/release pair for both reads and writes and rotates the target on each access. A stray start pulse is injected in the middle of selected accesses, so that rejection while busy is seen in the same runs as the windows themselves.

// File: rtl/lbcs_pkg.sv
package lbcs_pkg;

    localparam int LB_FIELD_W   = 4;
    localparam int LB_TREG_W    = 32;
    localparam int LB_REF_DLY   = 2;
    localparam int LB_MOTO_HOLD = 3;
    localparam int LB_CNT_W     = $clog2((1 << LB_FIELD_W) + LB_REF_DLY + 3);

    // Field slots inside the timing word (slot * LB_FIELD_W = bit offset)
    localparam int SLOT_RD_ON  = 0;
    localparam int SLOT_RD_OFF = 1;
    localparam int SLOT_WR_ON  = 2;
    localparam int SLOT_WR_OFF = 3;

    typedef logic [LB_CNT_W-1:0] lb_cnt_t;

    typedef struct packed {
        lb_cnt_t on_at;
        lb_cnt_t off_at;
    } lb_win_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } lb_seq_e;

    function automatic lb_cnt_t get_field(input logic [LB_TREG_W-1:0] word, input int slot);
        return lb_cnt_t'(word[slot*LB_FIELD_W +: LB_FIELD_W]);
    endfunction

    function automatic lb_cnt_t release_point(input lb_cnt_t on_at, input lb_cnt_t off_at);
        return (off_at > on_at) ? off_at : lb_cnt_t'(on_at + lb_cnt_t'(1));
    endfunction

endpackage

// File: rtl/lbcs_timing_sel.sv
module lbcs_timing_sel
    import lbcs_pkg::*;
(
    input  logic                 write_i,
    input  logic                 moto_mode_i,
    input  logic [LB_TREG_W-1:0] timing_i,
    output lb_win_t              win_o
);
    lb_cnt_t on_raw;
    lb_cnt_t off_raw;

    always_comb begin
        on_raw  = write_i ? get_field(timing_i, SLOT_WR_ON)  : get_field(timing_i, SLOT_RD_ON);
        off_raw = write_i ? get_field(timing_i, SLOT_WR_OFF) : get_field(timing_i, SLOT_RD_OFF);
        if (moto_mode_i) begin
            win_o.on_at  = '0;
            win_o.off_at = lb_cnt_t'(LB_MOTO_HOLD);
        end else begin
            win_o.on_at  = on_raw;
            win_o.off_at = release_point(on_raw, off_raw);
        end
    end

    always_comb begin
        AST_WIN_ORDERED: assert (win_o.off_at > win_o.on_at); // R4
    end

endmodule

// File: rtl/lbcs_seq_ctrl.sv
module lbcs_seq_ctrl
    import lbcs_pkg::*;
#(
    parameter int TGT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             hit_i,
    input  logic [TGT_W-1:0] tgt_i,
    input  lb_win_t          win_i,
    output logic [TGT_W-1:0] tgt_q_o,
    output logic             cs_on_next_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam lb_cnt_t REF = lb_cnt_t'(LB_REF_DLY);

    lb_seq_e          state_q;
    lb_cnt_t          tick_q;
    lb_win_t          win_q;
    logic [TGT_W-1:0] tgt_q;
    lb_cnt_t          tick_nxt;
    logic             accept;

    assign accept   = (state_q == SEQ_IDLE) && start_i && hit_i;
    assign tick_nxt = tick_q + lb_cnt_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            tick_q  <= '0;
            win_q   <= '0;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        state_q <= SEQ_RUN;
                        tick_q  <= lb_cnt_t'(1);
                        win_q   <= win_i;
                        tgt_q   <= tgt_i;
                    end
                end
                SEQ_RUN: begin
                    tick_q <= tick_nxt;
                    if (tick_q == REF + win_q.off_at) begin
                        state_q <= SEQ_FIN;
                    end
                end
                SEQ_FIN: begin
                    state_q <= SEQ_IDLE;
                    tick_q  <= '0;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign cs_on_next_o = (state_q == SEQ_RUN)
                        && (tick_nxt >= REF + win_q.on_at)
                        && (tick_nxt <  REF + win_q.off_at);
    assign busy_o  = (state_q != SEQ_IDLE);
    assign done_o  = (state_q == SEQ_FIN);
    assign tgt_q_o = tgt_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_BUSY_HOLDS_TGT: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> $stable(tgt_q)); // R8
    AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && !hit_i) |=> !busy_o); // R9

endmodule

// File: rtl/lbcs_strobe_drv.sv
module lbcs_strobe_drv #(
    parameter int NUM_CS = 4,
    parameter int TGT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              on_next_i,
    input  logic [TGT_W-1:0]  tgt_i,
    output logic [NUM_CS-1:0] cs_n_o
);
    logic [NUM_CS-1:0] sel_n;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        assign sel_n[g] = !(on_next_i && (tgt_i == TGT_W'(g)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_o <= '1;
        end else begin
            cs_n_o <= sel_n;
        end
    end

    AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n_o) <= 1); // R5
    AST_RESET_HIGH: assert property (@(posedge clk)
        rst |=> (cs_n_o == '1)); // R1

endmodule

// File: rtl/lbcs_seq.sv
module lbcs_seq
    import lbcs_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int NUM_RG = 2,
    localparam int TGT_W = $clog2(NUM_CS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 write_i,
    input  logic [TGT_W-1:0]     target_i,
    input  logic [NUM_RG-1:0]    region_hit_i,
    input  logic                 moto_mode_i,
    input  logic [LB_TREG_W-1:0] timing_i,
    output logic [NUM_CS-1:0]    cs_n_o,
    output logic                 busy_o,
    output logic                 done_o
);
    lb_win_t          win;
    logic [TGT_W-1:0] tgt_q;
    logic             cs_on_next;

    lbcs_timing_sel u_tsel (
        .write_i     (write_i),
        .moto_mode_i (moto_mode_i),
        .timing_i    (timing_i),
        .win_o       (win)
    );

    lbcs_seq_ctrl #(.TGT_W(TGT_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .hit_i        (|region_hit_i),
        .tgt_i        (target_i),
        .win_i        (win),
        .tgt_q_o      (tgt_q),
        .cs_on_next_o (cs_on_next),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    lbcs_strobe_drv #(.NUM_CS(NUM_CS), .TGT_W(TGT_W)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .on_next_i (cs_on_next),
        .tgt_i     (tgt_q),
        .cs_n_o    (cs_n_o)
    );

    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cs_n_o == '1)); // R7
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (cs_n_o == '1)); // R2

endmodule

// File: tb/lbcs_seq_tb.sv
module lbcs_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic        write_i;
    logic [1:0]  target_i;
    logic [1:0]  region_hit_i;
    logic        moto_mode_i;
    logic [31:0] timing_i;
    logic [3:0]  cs_n_o;
    logic        busy_o;
    logic        done_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbcs_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .write_i(write_i),
        .target_i(target_i), .region_hit_i(region_hit_i),
        .moto_mode_i(moto_mode_i), .timing_i(timing_i),
        .cs_n_o(cs_n_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One access; returns with the bench in the idle cycle after done.
    task automatic run_access(input string req, input bit wr, input bit [1:0] tgt,
                              input bit moto, input bit [31:0] tw, input bit stray);
        int a, d, last;
        logic [3:0] exp_cs;
        if (moto) begin
            a = 0; d = 3;
        end else begin
            a = wr ? int'(tw[11:8])  : int'(tw[3:0]);
            d = wr ? int'(tw[15:12]) : int'(tw[7:4]);
            if (d <= a) d = a + 1;   // R4
        end
        last = 4 + d;
        write_i = wr; target_i = tgt; moto_mode_i = moto; timing_i = tw;
        region_hit_i = (tgt[0]) ? 2'b10 : 2'b01;
        start_i = 1'b1;
        for (int c = 1; c <= last; c++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            if (stray && c == 3) begin  // R8: stray pulse with other target/timing
                start_i = 1'b1; target_i = tgt + 2'd1; write_i = !wr; timing_i = ~tw;
                moto_mode_i = !moto;
            end
            exp_cs = 4'hF;
            if (c >= 2 + a && c < 2 + d) exp_cs[tgt] = 1'b0;
            check(req, {cs_n_o, busy_o, done_o},
                  {exp_cs, (c >= 1 && c <= 3 + d), (c == 3 + d)});
        end
        start_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1; start_i = 1'b0; write_i = 1'b0; target_i = '0;
        region_hit_i = 2'b01; moto_mode_i = 1'b0; timing_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", {cs_n_o, busy_o, done_o}, 6'b1111_0_0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 after reset", {cs_n_o, busy_o, done_o}, 6'b1111_0_0);

        // R2 / R4 / R5: every read field pair, target rotating
        for (int on = 0; on < 16; on++) begin
            for (int off = 0; off < 16; off++) begin
                run_access("R2 R4 R5 read", 1'b0, 2'((on + off) % 4), 1'b0,
                           {16'hA5C3, 4'((off + 5) % 16), 4'((on + 9) % 16), 4'(off), 4'(on)},
                           ((on + off) % 7) == 0);
            end
        end
        // R3 / R4: every write field pair, read fields hold decoys
        for (int on = 0; on < 16; on++) begin
            for (int off = 0; off < 16; off++) begin
                run_access("R3 R4 write", 1'b1, 2'((on * 3 + off) % 4), 1'b0,
                           {16'h3C5A, 4'(off), 4'(on), 4'(15 - on), 4'(15 - off)},
                           ((on + off) % 5) == 0);
            end
        end
        // R6: fixed window regardless of fields
        for (int k = 0; k < 32; k++) begin
            run_access("R6 fixed mode", k[0], 2'(k >> 1), 1'b1,
                       32'h9E37_79B9 * (k + 1), k[2]);
        end
        // R8: stray start explicitly on a long window
        run_access("R8 busy ignore", 1'b0, 2'd2, 1'b0, 32'h0000_00F4, 1'b1);

        // R9: start without region hit is ignored
        region_hit_i = 2'b00; timing_i = 32'h0000_0010; target_i = 2'd1;
        moto_mode_i = 1'b0; write_i = 1'b0; start_i = 1'b1;
        for (int c = 1; c <= 6; c++) begin
            @(posedge clk); @(negedge clk);
            start_i = 1'b0;
            check("R9 no hit", {cs_n_o, busy_o, done_o}, 6'b1111_0_0);
        end

        // R7: done pulse and busy span after a one-clock window at the far end
        run_access("R7 done at far end", 1'b1, 2'd3, 1'b0, 32'h0000_0F00, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule